// File: doc/BRIEF.md
# Outstanding Line-Miss Tracker

This block keeps a small table of cache lines whose refill from memory is still pending, so that a non-blocking data cache can go on serving hits while those lines are on their way. Each table slot describes one whole memory line: its line address and, for every word position inside that line, the destination register that waits for that word, if there is one. A first miss to a line takes a free slot and sends exactly one read request towards memory. Later misses to the same line do not go to memory again. They join the existing slot by recording their destination register against the word they need.

Each accepted miss is acknowledged in the same cycle. The pipeline can then mark the destination register as empty and let the load move on. When memory returns the whole line for a slot, the block writes back the waiting words one per cycle, each with its register tag and data, and then frees the slot. A miss that cannot be taken is answered with a stall in the same cycle, and the table does not change. This happens when the table is full, when the slot's word already has a waiting register, or when the slot is being refilled.

Top module: `miss_tracker`

## Requirements
- R1: While reset is asserted and in the cycle after it, there is no memory request and no writeback, the stall is low and the refill port reports ready.
- R2: A miss to a line not in the table, with a free slot present, is accepted. In the same cycle the block raises a memory request that carries the miss line address.
- R3: A miss to a line already held in a slot that is not being refilled, for a word with no waiting register, is accepted with the acknowledge high and no memory request. No two valid slots ever hold the same line.
- R4: A miss to a held line whose requested word already has a waiting register is stalled and leaves the table unchanged.
- R5: A miss to a new line while all slots are valid is stalled, and no memory request is raised while all slots are valid.
- R6: A refill for a valid slot is accepted only while the refill port reports ready. Ready is low from the cycle after acceptance until the last writeback of that line.
- R7: Starting the cycle after a refill is accepted, the block emits one writeback per cycle, one for each waiting word of that slot in ascending word order. Each writeback carries the waiting register tag, and the data is word w of the refill, taken from bits [w*DATA_W +: DATA_W].
- R8: New allocations take the lowest-numbered free slot, and the request carries that slot number as its identifier. A slot is freed at the clock edge of its last writeback and can be allocated in the next cycle.
- R9: A miss to a line whose slot is being drained, or whose refill is accepted in the same cycle, is stalled.
- R10: A memory request appears only in a cycle where a miss is present and not stalled, and only once per allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | WIDX_W | Word position within the line |
| miss_reg | input | REG_W | Destination register of the load |
| miss_stall | output | 1 | Miss cannot be taken this cycle |
| miss_taken | output | 1 | Miss accepted; destination register may be marked empty |
| mem_req_valid | output | 1 | Read request for a newly allocated line |
| mem_req_line | output | LINE_W | Line address of the request |
| mem_req_id | output | ID_W | Slot number; returned with the refill |
| fill_valid | input | 1 | Refill data present |
| fill_id | input | ID_W | Slot the refill belongs to |
| fill_data | input | WORDS*DATA_W | Whole line, word w at bits [w*DATA_W +: DATA_W] |
| fill_ready | output | 1 | Refill can be accepted |
| wb_valid | output | 1 | Register writeback present |
| wb_reg | output | REG_W | Register to write |
| wb_data | output | DATA_W | Word value for that register |

## Verification
The hardest case to reach is a miss that targets the very line whose refill is being accepted in the same cycle. Both inputs have to line up on one edge, and a missed stall there would drop a register silently. A directed opening sequence places that case, a same-word conflict, a full table and the reuse of a just-freed slot on exact cycles. After that, a long random phase draws misses from a pool of only six lines and returns refills at random moments, so merges, conflicts and full-table stalls keep recurring against a behavioural model of the table.

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  parameter int WORDS   = 4,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  localparam int ID_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_valid,
  input  logic [LINE_W-1:0]       miss_line,
  input  logic [WIDX_W-1:0]       miss_word,
  input  logic [REG_W-1:0]        miss_reg,
  output logic                    miss_stall,
  output logic                    miss_taken,
  output logic                    mem_req_valid,
  output logic [LINE_W-1:0]       mem_req_line,
  output logic [ID_W-1:0]         mem_req_id,
  input  logic                    fill_valid,
  input  logic [ID_W-1:0]         fill_id,
  input  logic [WORDS*DATA_W-1:0] fill_data,
  output logic                    fill_ready,
  output logic                    wb_valid,
  output logic [REG_W-1:0]        wb_reg,
  output logic [DATA_W-1:0]       wb_data
);

  logic [ENTRIES-1:0] ent_valid;
  logic [LINE_W-1:0]  ent_line [ENTRIES];
  logic [WORDS-1:0]   ent_wait [ENTRIES];
  logic [REG_W-1:0]   ent_reg  [ENTRIES][WORDS];

  logic               drain_busy;
  logic [ID_W-1:0]    drain_id;
  logic [WORDS-1:0]   drain_mask;
  logic [DATA_W-1:0]  drain_words [WORDS];

  logic [ENTRIES-1:0] match_vec, busy_vec;
  logic [ID_W-1:0]    hit_id, free_id;
  logic [WIDX_W-1:0]  drain_w;
  logic               fill_fire, hit, hit_busy, word_busy, full, alloc;
  logic [WORDS-1:0]   drain_rest;

  assign fill_ready = !drain_busy;
  assign fill_fire  = fill_valid && fill_ready && ent_valid[fill_id];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = ent_valid[i] && (ent_line[i] == miss_line);
    assign busy_vec[i]  = (drain_busy && drain_id == ID_W'(i)) ||
                          (fill_fire && fill_id == ID_W'(i));
  end

  always_comb begin
    hit_id  = '0;
    free_id = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i])  hit_id  = ID_W'(i);
      if (!ent_valid[i]) free_id = ID_W'(i);
    end
  end

  assign hit        = |match_vec;
  assign hit_busy   = |(match_vec & busy_vec);
  assign word_busy  = hit && ent_wait[hit_id][miss_word];
  assign full       = &ent_valid;
  assign miss_stall = miss_valid && (hit ? (hit_busy || word_busy) : full);
  assign miss_taken = miss_valid && !miss_stall;
  assign alloc      = miss_taken && !hit;

  assign mem_req_valid = alloc;
  assign mem_req_line  = miss_line;
  assign mem_req_id    = free_id;

  always_comb begin
    drain_w = '0;
    for (int w = WORDS - 1; w >= 0; w--)
      if (drain_mask[w]) drain_w = WIDX_W'(w);
  end

  assign drain_rest = drain_mask & (drain_mask - WORDS'(1));
  assign wb_valid   = drain_busy;
  assign wb_reg     = ent_reg[drain_id][drain_w];
  assign wb_data    = drain_words[drain_w];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid  <= '0;
      drain_busy <= 1'b0;
      drain_id   <= '0;
      drain_mask <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_line[i] <= '0;
        ent_wait[i] <= '0;
        for (int w = 0; w < WORDS; w++) ent_reg[i][w] <= '0;
      end
      for (int w = 0; w < WORDS; w++) drain_words[w] <= '0;
    end else begin
      if (alloc) begin
        ent_valid[free_id]          <= 1'b1;
        ent_line[free_id]           <= miss_line;
        ent_wait[free_id]           <= WORDS'(1) << miss_word;
        ent_reg[free_id][miss_word] <= miss_reg;
      end
      if (miss_taken && hit) begin
        ent_wait[hit_id][miss_word] <= 1'b1;
        ent_reg[hit_id][miss_word]  <= miss_reg;
      end
      if (fill_fire) begin
        drain_busy <= 1'b1;
        drain_id   <= fill_id;
        drain_mask <= ent_wait[fill_id];
        for (int w = 0; w < WORDS; w++)
          drain_words[w] <= fill_data[w*DATA_W +: DATA_W];
      end else if (drain_busy) begin
        drain_mask <= drain_rest;
        if (drain_rest == '0) begin
          drain_busy          <= 1'b0;
          ent_valid[drain_id] <= 1'b0;
          ent_wait[drain_id]  <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/miss_tracker_chk.sv
module miss_tracker_chk #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  parameter int ID_W    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               miss_valid,
  input logic               miss_stall,
  input logic               mem_req_valid,
  input logic               fill_valid,
  input logic [ID_W-1:0]    fill_id,
  input logic               fill_ready,
  input logic               wb_valid,
  input logic [ENTRIES-1:0] ent_valid,
  input logic [ENTRIES-1:0] match_vec,
  input logic [WORDS-1:0]   drain_mask
);

  AST_REQ_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (miss_valid && !miss_stall)); // R10

  AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_valid) |-> !mem_req_valid); // R5

  AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R3

  AST_STALL_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_stall |-> miss_valid); // R4

  AST_FILL_STARTS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready && ent_valid[fill_id]) |=> wb_valid); // R7

  AST_DRAIN_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && $countones(drain_mask) > 1) |=> (wb_valid && !fill_ready)); // R6

endmodule

bind miss_tracker miss_tracker_chk #(.ENTRIES(ENTRIES), .WORDS(WORDS), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_stall(miss_stall),
  .mem_req_valid(mem_req_valid), .fill_valid(fill_valid), .fill_id(fill_id),
  .fill_ready(fill_ready), .wb_valid(wb_valid), .ent_valid(ent_valid),
  .match_vec(match_vec), .drain_mask(drain_mask)
);

// File: tb/miss_tracker_tb_top.sv
`timescale 1ns/1ps
module miss_tracker_tb_top;
  localparam int N = 4, LINE_W = 26, WORDS = 4, REG_W = 5, DATA_W = 32, ID_W = 2, WIDX_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, fill_valid = 1'b0;
  logic [LINE_W-1:0] miss_line = '0;
  logic [WIDX_W-1:0] miss_word = '0;
  logic [REG_W-1:0]  miss_reg = '0;
  logic [ID_W-1:0]   fill_id = '0;
  logic [WORDS*DATA_W-1:0] fill_data = '0;
  logic miss_stall, miss_taken, mem_req_valid, fill_ready, wb_valid;
  logic [LINE_W-1:0] mem_req_line;
  logic [ID_W-1:0]   mem_req_id;
  logic [REG_W-1:0]  wb_reg;
  logic [DATA_W-1:0] wb_data;

  always #10 clk = ~clk;

  miss_tracker dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  bit               mv [N];
  logic [LINE_W-1:0] ml [N];
  logic [WORDS-1:0]  mw [N];
  logic [REG_W-1:0]  mr [N][WORDS];
  bit md_busy = 0;
  int md_id = 0;
  logic [WORDS-1:0] md_mask = '0;
  logic [WORDS*DATA_W-1:0] md_data = '0;

  bit e_ready, e_fire, e_hit, e_full, e_busyhit, e_wordw, e_stall, e_take, e_alloc, e_wb;
  int e_hid, e_fid, e_dw;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    e_ready = !md_busy;
    e_fire  = fill_valid && e_ready && mv[int'(fill_id)];
    e_hit = 0; e_hid = 0;
    for (int i = 0; i < N; i++) if (mv[i] && ml[i] == miss_line) begin e_hit = 1; e_hid = i; end
    e_full = 1; e_fid = 0;
    for (int i = N - 1; i >= 0; i--) if (!mv[i]) begin e_full = 0; e_fid = i; end
    e_busyhit = e_hit && ((md_busy && md_id == e_hid) || (e_fire && int'(fill_id) == e_hid));
    e_wordw   = e_hit && mw[e_hid][miss_word];
    e_stall   = miss_valid && (e_hit ? (e_busyhit || e_wordw) : e_full);
    e_take    = miss_valid && !e_stall;
    e_alloc   = e_take && !e_hit;
    e_wb      = md_busy;
    e_dw = 0;
    for (int w = WORDS - 1; w >= 0; w--) if (md_mask[w]) e_dw = w;
  endtask

  task automatic model_commit();
    if (e_alloc) begin
      mv[e_fid] = 1; ml[e_fid] = miss_line; mw[e_fid] = '0;
      mw[e_fid][miss_word] = 1'b1; mr[e_fid][miss_word] = miss_reg;
    end
    if (e_take && e_hit) begin
      mw[e_hid][miss_word] = 1'b1; mr[e_hid][miss_word] = miss_reg;
    end
    if (e_fire) begin
      md_busy = 1; md_id = int'(fill_id); md_mask = mw[int'(fill_id)]; md_data = fill_data;
    end else if (md_busy) begin
      md_mask[e_dw] = 1'b0;
      if (md_mask == '0) begin md_busy = 0; mv[md_id] = 0; mw[md_id] = '0; end
    end
  endtask

  task automatic step(input logic mvi, input logic [LINE_W-1:0] ln, input int wd, input int rg,
                      input logic fv, input int fid);
    string st;
    @(negedge clk);
    miss_valid = mvi; miss_line = ln; miss_word = WIDX_W'(wd); miss_reg = REG_W'(rg);
    fill_valid = fv; fill_id = ID_W'(fid);
    fill_data = {$urandom, $urandom, $urandom, $urandom};
    #2;
    model_eval();
    if (e_hit && e_busyhit) st = "R9";
    else if (e_hit && e_wordw) st = "R4";
    else if (!e_hit && e_full && miss_valid) st = "R5";
    else if (e_hit) st = "R3";
    else st = "R2";
    chk(st, 64'(miss_stall), 64'(e_stall));
    chk("R3 acknowledge", 64'(miss_taken), 64'(e_take));
    chk("R10 request", 64'(mem_req_valid), 64'(e_alloc));
    if (e_alloc) begin
      chk("R2 line", 64'(mem_req_line), 64'(miss_line));
      chk("R8 slot", 64'(mem_req_id), 64'(e_fid));
    end
    chk("R6 ready", 64'(fill_ready), 64'(e_ready));
    chk("R7 wb valid", 64'(wb_valid), 64'(e_wb));
    if (e_wb) begin
      chk("R7 wb reg", 64'(wb_reg), 64'(mr[md_id][e_dw]));
      chk("R7 wb data", 64'(wb_data), 64'(md_data[e_dw*DATA_W +: DATA_W]));
    end
    @(posedge clk);
    model_commit();
  endtask

  function automatic logic [LINE_W-1:0] ln_of(input int k);
    return LINE_W'(32'h100 + k);
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; ml[i] = '0; mw[i] = '0;
      for (int w = 0; w < WORDS; w++) mr[i][w] = '0; end
    repeat (3) begin
      @(negedge clk); #2;
      chk("R1 stall", 64'(miss_stall), 64'(0));
      chk("R1 request", 64'(mem_req_valid), 64'(0));
      chk("R1 wb", 64'(wb_valid), 64'(0));
      chk("R1 ready", 64'(fill_ready), 64'(1));
    end
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R1 after release", 64'(wb_valid | mem_req_valid), 64'(0));

    step(1, ln_of(0), 0, 1, 0, 0);   // R2 first allocation, slot 0
    step(1, ln_of(0), 2, 2, 0, 0);   // R3 merge word 2
    step(1, ln_of(0), 2, 3, 0, 0);   // R4 same word, stalled
    step(1, ln_of(1), 1, 4, 0, 0);
    step(1, ln_of(2), 1, 5, 0, 0);
    step(1, ln_of(3), 1, 6, 0, 0);
    step(1, ln_of(4), 0, 7, 0, 0);   // R5 table full
    step(1, ln_of(0), 1, 8, 1, 0);   // R9 refill accepted same cycle
    step(1, ln_of(0), 3, 9, 0, 0);   // R9 during drain, R7 word 0
    step(0, '0, 0, 0, 1, 2);         // R6 refill refused while draining
    step(1, ln_of(4), 0, 10, 0, 0);  // R8 freed slot 0 reused
    for (int c = 0; c < 6; c++) step(0, '0, 0, 0, 0, 0);

    for (int c = 0; c < 4000; c++) begin
      int fid = $urandom % N;
      logic fv = (mv[fid] && !md_busy && ($urandom % 4 == 0));
      step(($urandom % 5) < 3, ln_of($urandom % 6), $urandom % WORDS, $urandom % 32, fv, fid);
    end

    for (int c = 0; c < 200; c++) begin
      int fid = 0;
      logic fv = 0;
      for (int i = N - 1; i >= 0; i--) if (mv[i]) begin fid = i; fv = 1; end
      step(0, '0, 0, 0, fv && !md_busy, fid);
    end
    chk("R8 all slots freed", 64'(mv[0] | mv[1] | mv[2] | mv[3]), 64'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule